// File: doc/BRIEF.md
# Dual-Port Interprocessor Message Box

This block lets two processors on the same clock pass 32-bit words to each other. Each side is called local or remote, and each side has its own register port and its own interrupt line. There are eight channels, and each one carries words in a single direction through a small FIFO. The remote side sets the direction of every channel. From then on, the transmitting side writes a channel's data register to enqueue a word, and the receiving side reads the same register to dequeue the oldest word.

Each side has an interrupt enable word and an interrupt status word. Both sides can read both pairs of words, so a sender can watch the receiver's receive-status bit. A receive-status bit cannot be cleared while its FIFO still holds words. Once the bit drops, the sender knows the message was taken. The port address is a word address, equal to the byte offset divided by four.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, every FIFO is empty, every enable bit and every direction bit is 0, both interrupt lines are low, and both read-data outputs read 0.
- R2: Word addresses 0x00 and 0x01 (byte 0x000 and 0x004) hold the direction bits. Channel n is in word n/4, with its receive bit at bit 8*(n%4) and its transmit bit at bit 8*(n%4)+4. Only writes from the remote port take effect. Every other bit reads 0.
- R3: When a channel's receive bit alone is set, the local side receives; when its transmit bit alone is set, the local side transmits. The transmitting side writes word address 0x60+n to enqueue. The receiving side reads the same address to get words back in order. The count at word address 0x50+n gives the number of stored words.
- R4: Each FIFO holds 4 words. Bit 0 at word address 0x40+n reads 1 when the FIFO is full. A write to a full FIFO is dropped and the stored words stay unchanged.
- R5: A data write from the receiving side is dropped. A data read from the transmitting side, or from an empty FIFO, returns 0 and removes nothing. A channel with both direction bits set, or with neither set, accepts no word.
- R6: In a side's status word, bit 2n (receive) is set while channel n's FIFO is non-empty and that side receives on it. Bit 2n+1 (transmit) is set while the FIFO has room and that side transmits on it.
- R7: Writing 1 to a status bit clears it only when the bit's set condition is false in that cycle. A receive bit written with 1 while words remain stays set. Once set, a bit stays set until it is cleared.
- R8: The remote side's enable and status are at word addresses 0x10 and 0x14 (byte 0x040 and 0x050). The local side's are at 0x18 and 0x1C (byte 0x060 and 0x070). A port may write only its own side's pair. A side's interrupt line is the OR of (status AND enable).
- R9: Each port can read the other side's enable and status words. After the receiver drains a channel and clears its receive bit, the sender reads that bit as 0.
- R10: A push and a pop on one channel in the same cycle leave the count unchanged and keep word order, including when the FIFO is full. On an empty FIFO, the same pair stores the pushed word and the read returns 0.
- R11: Read data appears on the port's read-data output on the cycle after the read strobe. It holds that value until the port's next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_addr | input | 7 | Local port word address |
| loc_wr | input | 1 | Local write strobe |
| loc_rd | input | 1 | Local read strobe |
| loc_wdata | input | 32 | Local write data |
| loc_rdata | output | 32 | Local read data, registered |
| loc_irq | output | 1 | Local interrupt |
| rem_addr | input | 7 | Remote port word address |
| rem_wr | input | 1 | Remote write strobe |
| rem_rd | input | 1 | Remote read strobe |
| rem_wdata | input | 32 | Remote write data |
| rem_rdata | output | 32 | Remote read data, registered |
| rem_irq | output | 1 | Remote interrupt |

## Verification
Two things can happen on one channel in the same clock cycle: the sender enqueues a word while the receiver dequeues one. The bench drives both ports in one cycle, once on an empty FIFO and once on a full FIFO. It then checks three things: the word returned, the count read back afterwards, and the order of the words drained after that. The expected sequences come from a simple first-in-first-out count kept in the bench.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

   localparam int AW = 7;
   localparam int DW = 32;

   // word addresses with fixed meaning
   localparam logic [AW-1:0] A_CTL0 = 7'h00;
   localparam logic [AW-1:0] A_CTL1 = 7'h01;
   localparam logic [AW-1:0] A_REN  = 7'h10;
   localparam logic [AW-1:0] A_RST  = 7'h14;
   localparam logic [AW-1:0] A_LEN  = 7'h18;
   localparam logic [AW-1:0] A_LST  = 7'h1C;

   // per-channel pages, selected by address bits [6:3]
   localparam logic [3:0] PG_FULL = 4'h8;
   localparam logic [3:0] PG_CNT  = 4'hA;
   localparam logic [3:0] PG_DATA = 4'hC;

   function automatic int rx_pos(input int ch);
      return 8 * (ch % 4);
   endfunction

   function automatic int tx_pos(input int ch);
      return 8 * (ch % 4) + 4;
   endfunction

   // implemented direction bits of one control word
   function automatic logic [DW-1:0] ctl_mask(input int word, input int nch);
      logic [DW-1:0] m;
      m = '0;
      for (int k = 0; k < 4; k++) begin
         if (word * 4 + k < nch) begin
            m[rx_pos(k)] = 1'b1;
            m[tx_pos(k)] = 1'b1;
         end
      end
      return m;
   endfunction

endpackage

// File: rtl/ipc_mbox_fifo.sv
module ipc_mbox_fifo #(
   parameter int DEPTH = 4,
   parameter int DW    = 32,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] head,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   localparam int PW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("ipc_mbox_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt_q;
   logic          accept;

   assign full   = (cnt_q == CW'(DEPTH));
   assign empty  = (cnt_q == '0);
   // a pop in the same cycle frees the slot a full FIFO needs
   assign accept = push && (!full || pop);
   assign head   = mem[rp];
   assign count  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         cnt_q <= '0;
      end else begin
         if (accept) wp <= wp + 1'b1;
         if (pop)    rp <= rp + 1'b1;
         case ({accept, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (accept) mem[wp] <= din;
   end

   assert_no_overflow_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));

   assert_no_underflow_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

   assert_drop_full_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && full) |=> $stable(cnt_q));

   assert_pushpop_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop) |=> $stable(cnt_q));

endmodule

// File: rtl/ipc_mbox_irq_bank.sv
module ipc_mbox_irq_bank #(
   parameter int NB = 16,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_we,
   input  logic          clr_we,
   input  logic [DW-1:0] wdata,
   input  logic [NB-1:0] set,
   output logic [NB-1:0] en,
   output logic [NB-1:0] stat,
   output logic          irq
);

   generate
      if (NB > DW) begin : g_bad_nb
         $error("ipc_mbox_irq_bank: NB exceeds the data width");
      end
   endgenerate

   logic [NB-1:0] clr;

   assign clr = clr_we ? wdata[NB-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en   <= '0;
         stat <= '0;
      end else begin
         if (en_we) en <= wdata[NB-1:0];
         // a live set condition outranks a clear request
         stat <= set | (stat & ~clr);
      end
   end

   assign irq = |(stat & en);

   assert_set_wins_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (set != '0) |=> ((stat & $past(set)) == $past(set)));

   assert_irq_quiet_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq);

endmodule

// File: rtl/ipc_mbox_port.sv
module ipc_mbox_port
   import ipc_mbox_pkg::*;
#(
   parameter bit IS_REMOTE = 1'b0,
   parameter int NUM_CH    = 8,
   parameter int CW        = 3,
   parameter bit RDATA_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [NUM_CH-1:0] dir_tx,
   input  logic [NUM_CH-1:0] dir_rx,
   input  logic [NUM_CH-1:0] full,
   input  logic [NUM_CH-1:0] empty,
   input  logic [CW-1:0]     cnt  [NUM_CH],
   input  logic [DW-1:0]     head [NUM_CH],
   input  logic [DW-1:0]     ctl0,
   input  logic [DW-1:0]     ctl1,
   input  logic [2*NUM_CH-1:0] en_loc,
   input  logic [2*NUM_CH-1:0] st_loc,
   input  logic [2*NUM_CH-1:0] en_rem,
   input  logic [2*NUM_CH-1:0] st_rem,
   output logic [NUM_CH-1:0] push,
   output logic [NUM_CH-1:0] pop,
   output logic [1:0]        ctl_we,
   output logic              en_we,
   output logic              clr_we,
   output logic [DW-1:0]     rdata
);

   localparam logic [AW-1:0] OWN_EN = IS_REMOTE ? A_REN : A_LEN;
   localparam logic [AW-1:0] OWN_ST = IS_REMOTE ? A_RST : A_LST;

   logic [2:0]    ch;
   logic [3:0]    page;
   logic [DW-1:0] rmux;

   assign ch   = addr[2:0];
   assign page = addr[6:3];

   always_comb begin
      for (int i = 0; i < NUM_CH; i++) begin
         push[i] = wr && (page == PG_DATA) && (ch == 3'(i)) && dir_tx[i];
         pop[i]  = rd && (page == PG_DATA) && (ch == 3'(i)) && dir_rx[i] && !empty[i];
      end
   end

   assign en_we  = wr && (addr == OWN_EN);
   assign clr_we = wr && (addr == OWN_ST);

   generate
      if (IS_REMOTE) begin : g_ctl_owner
         assign ctl_we = {wr && (addr == A_CTL1), wr && (addr == A_CTL0)};
      end else begin : g_ctl_none
         assign ctl_we = 2'b00;
      end
   endgenerate

   always_comb begin
      rmux = '0;
      case (addr)
         A_CTL0: rmux = ctl0;
         A_CTL1: rmux = ctl1;
         A_REN:  rmux = DW'(en_rem);
         A_RST:  rmux = DW'(st_rem);
         A_LEN:  rmux = DW'(en_loc);
         A_LST:  rmux = DW'(st_loc);
         default: begin
            for (int i = 0; i < NUM_CH; i++) begin
               if (ch == 3'(i)) begin
                  if (page == PG_FULL) rmux = DW'(full[i]);
                  if (page == PG_CNT)  rmux = DW'(cnt[i]);
                  if (page == PG_DATA && dir_rx[i] && !empty[i]) rmux = head[i];
               end
            end
         end
      endcase
   end

   generate
      if (RDATA_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  rdata <= '0;
            else if (rd) rdata <= rmux;
         end

         assert_rd_hold_R11 : assert property (@(posedge clk) disable iff (!rst_n)
            !rd |=> $stable(rdata));
      end else begin : g_rd_comb
         assign rdata = rd ? rmux : '0;
      end
   endgenerate

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
   import ipc_mbox_pkg::*;
#(
   parameter int NUM_CH    = 8,
   parameter int DEPTH     = 4,
   parameter bit RDATA_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] loc_addr,
   input  logic          loc_wr,
   input  logic          loc_rd,
   input  logic [DW-1:0] loc_wdata,
   output logic [DW-1:0] loc_rdata,
   output logic          loc_irq,
   input  logic [AW-1:0] rem_addr,
   input  logic          rem_wr,
   input  logic          rem_rd,
   input  logic [DW-1:0] rem_wdata,
   output logic [DW-1:0] rem_rdata,
   output logic          rem_irq
);

   localparam int CW = $clog2(DEPTH + 1);
   localparam int NB = 2 * NUM_CH;

   generate
      if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_nch
         $error("ipc_mailbox: NUM_CH must lie in 1..8");
      end
      if (DEPTH != 2 && DEPTH != 4) begin : g_bad_depth
         $error("ipc_mailbox: DEPTH must be 2 or 4 for the 3-bit count");
      end
   endgenerate

   // side index 0 is local, 1 is remote
   logic [AW-1:0]     s_addr  [2];
   logic              s_wr    [2];
   logic              s_rd    [2];
   logic [DW-1:0]     s_wdata [2];
   logic [DW-1:0]     s_rdata [2];
   logic [NUM_CH-1:0] s_push  [2];
   logic [NUM_CH-1:0] s_pop   [2];
   logic [NUM_CH-1:0] s_dtx   [2];
   logic [NUM_CH-1:0] s_drx   [2];
   logic [1:0]        s_ctl_we[2];
   logic              s_en_we [2];
   logic              s_clr_we[2];
   logic [NB-1:0]     en_s    [2];
   logic [NB-1:0]     st_s    [2];
   logic [NB-1:0]     set_s   [2];
   logic              irq_s   [2];

   logic [DW-1:0]     ctl_q [2];
   logic [NUM_CH-1:0] ltx, lrx, empty, full, f_push, f_pop;
   logic [DW-1:0]     f_din [NUM_CH];
   logic [DW-1:0]     head  [NUM_CH];
   logic [CW-1:0]     cnt   [NUM_CH];

   assign s_addr[0]  = loc_addr;
   assign s_wr[0]    = loc_wr;
   assign s_rd[0]    = loc_rd;
   assign s_wdata[0] = loc_wdata;
   assign s_addr[1]  = rem_addr;
   assign s_wr[1]    = rem_wr;
   assign s_rd[1]    = rem_rd;
   assign s_wdata[1] = rem_wdata;
   assign loc_rdata  = s_rdata[0];
   assign rem_rdata  = s_rdata[1];
   assign loc_irq    = irq_s[0];
   assign rem_irq    = irq_s[1];

   // direction words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q[0] <= '0;
         ctl_q[1] <= '0;
      end else begin
         for (int w = 0; w < 2; w++) begin
            if (s_ctl_we[0][w] || s_ctl_we[1][w])
               ctl_q[w] <= (s_ctl_we[1][w] ? s_wdata[1] : s_wdata[0]) & ctl_mask(w, NUM_CH);
         end
      end
   end

   generate
      for (genvar n = 0; n < NUM_CH; n++) begin : g_dir
         logic rxb, txb;
         assign rxb    = ctl_q[n / 4][rx_pos(n)];
         assign txb    = ctl_q[n / 4][tx_pos(n)];
         assign lrx[n] = rxb && !txb;
         assign ltx[n] = txb && !rxb;
      end
   endgenerate

   assign s_dtx[0] = ltx;
   assign s_drx[0] = lrx;
   assign s_dtx[1] = lrx;
   assign s_drx[1] = ltx;

   // FIFO inputs and status set conditions
   always_comb begin
      for (int n = 0; n < NUM_CH; n++) begin
         f_push[n] = s_push[0][n] || s_push[1][n];
         f_pop[n]  = s_pop[0][n]  || s_pop[1][n];
         f_din[n]  = s_push[1][n] ? s_wdata[1] : s_wdata[0];
      end
      for (int n = 0; n < NUM_CH; n++) begin
         set_s[0][2*n]   = lrx[n] && !empty[n];
         set_s[0][2*n+1] = ltx[n] && !full[n];
         set_s[1][2*n]   = ltx[n] && !empty[n];
         set_s[1][2*n+1] = lrx[n] && !full[n];
      end
   end

   generate
      for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
         ipc_mbox_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) i_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (f_push[n]),
            .pop   (f_pop[n]),
            .din   (f_din[n]),
            .head  (head[n]),
            .count (cnt[n]),
            .full  (full[n]),
            .empty (empty[n])
         );
      end

      for (genvar s = 0; s < 2; s++) begin : g_side
         ipc_mbox_irq_bank #(.NB(NB), .DW(DW)) i_irq (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_we  (s_en_we[s]),
            .clr_we (s_clr_we[s]),
            .wdata  (s_wdata[s]),
            .set    (set_s[s]),
            .en     (en_s[s]),
            .stat   (st_s[s]),
            .irq    (irq_s[s])
         );

         ipc_mbox_port #(
            .IS_REMOTE (s == 1),
            .NUM_CH    (NUM_CH),
            .CW        (CW),
            .RDATA_REG (RDATA_REG)
         ) i_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .addr   (s_addr[s]),
            .wr     (s_wr[s]),
            .rd     (s_rd[s]),
            .dir_tx (s_dtx[s]),
            .dir_rx (s_drx[s]),
            .full   (full),
            .empty  (empty),
            .cnt    (cnt),
            .head   (head),
            .ctl0   (ctl_q[0]),
            .ctl1   (ctl_q[1]),
            .en_loc (en_s[0]),
            .st_loc (st_s[0]),
            .en_rem (en_s[1]),
            .st_rem (st_s[1]),
            .push   (s_push[s]),
            .pop    (s_pop[s]),
            .ctl_we (s_ctl_we[s]),
            .en_we  (s_en_we[s]),
            .clr_we (s_clr_we[s]),
            .rdata  (s_rdata[s])
         );
      end
   endgenerate

   assert_dir_excl_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (s_push[0] & s_push[1]) == '0);

   assert_ctl_local_ignored_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (loc_wr && (loc_addr == A_CTL0 || loc_addr == A_CTL1) &&
       !(rem_wr && (rem_addr == A_CTL0 || rem_addr == A_CTL1)))
      |=> ($stable(ctl_q[0]) && $stable(ctl_q[1])));

endmodule

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [6:0]  loc_addr, rem_addr;
   logic        loc_wr, loc_rd, rem_wr, rem_rd;
   logic [31:0] loc_wdata, rem_wdata, loc_rdata, rem_rdata;
   logic        loc_irq, rem_irq;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // channel plan: direction bits as written by the remote side
   bit btx [8] = '{1, 0, 1, 0, 1, 0, 1, 0};
   bit brx [8] = '{0, 1, 0, 1, 0, 1, 1, 0};

   always #5 clk = ~clk;

   ipc_mailbox i_ipc_mailbox (
      .clk       (clk),
      .rst_n     (rst_n),
      .loc_addr  (loc_addr),
      .loc_wr    (loc_wr),
      .loc_rd    (loc_rd),
      .loc_wdata (loc_wdata),
      .loc_rdata (loc_rdata),
      .loc_irq   (loc_irq),
      .rem_addr  (rem_addr),
      .rem_wr    (rem_wr),
      .rem_rd    (rem_rd),
      .rem_wdata (rem_wdata),
      .rem_rdata (rem_rdata),
      .rem_irq   (rem_irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic duo(input logic lw, input logic lr, input logic [6:0] la, input logic [31:0] ld,
                      input logic rw, input logic rr, input logic [6:0] ra, input logic [31:0] rdv,
                      output logic [31:0] lq, output logic [31:0] rq);
      @(negedge clk);
      loc_wr = lw; loc_rd = lr; loc_addr = la; loc_wdata = ld;
      rem_wr = rw; rem_rd = rr; rem_addr = ra; rem_wdata = rdv;
      @(negedge clk);
      loc_wr = 1'b0; loc_rd = 1'b0; rem_wr = 1'b0; rem_rd = 1'b0;
      lq = loc_rdata;
      rq = rem_rdata;
   endtask

   task automatic wr(input bit rem, input logic [6:0] a, input logic [31:0] d);
      logic [31:0] x, y;
      if (rem) duo(1'b0, 1'b0, 7'h0, 32'h0, 1'b1, 1'b0, a, d, x, y);
      else     duo(1'b1, 1'b0, a, d, 1'b0, 1'b0, 7'h0, 32'h0, x, y);
   endtask

   task automatic rd(input bit rem, input logic [6:0] a, output logic [31:0] q);
      logic [31:0] x, y;
      if (rem) begin
         duo(1'b0, 1'b0, 7'h0, 32'h0, 1'b0, 1'b1, a, 32'h0, x, y);
         q = y;
      end else begin
         duo(1'b0, 1'b1, a, 32'h0, 1'b0, 1'b0, 7'h0, 32'h0, x, y);
         q = x;
      end
   endtask

   function automatic logic [31:0] ctlw(input int w);
      logic [31:0] r = '0;
      for (int k = 0; k < 4; k++) begin
         if (btx[4*w+k]) r[8*k+4] = 1'b1;
         if (brx[4*w+k]) r[8*k]   = 1'b1;
      end
      return r;
   endfunction

   function automatic logic [31:0] val(input int n, input int i);
      return {8'hA5, 8'(n), 8'h3C, 8'(i)};
   endfunction

   function automatic logic [6:0] st_addr(input bit rem);
      return rem ? 7'h14 : 7'h1C;
   endfunction

   initial begin
      logic [31:0] q, lq, rq;
      rst_n = 1'b0;
      loc_addr = '0; loc_wr = 1'b0; loc_rd = 1'b0; loc_wdata = '0;
      rem_addr = '0; rem_wr = 1'b0; rem_rd = 1'b0; rem_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 loc_irq", 32'(loc_irq), 0);
      check("R1 rem_irq", 32'(rem_irq), 0);
      check("R1 loc_rdata", loc_rdata, 0);
      check("R1 rem_rdata", rem_rdata, 0);
      for (int n = 0; n < 8; n++) begin
         rd(1'b1, 7'h50 + 7'(n), q);
         check("R1 count", q, 0);
      end
      rd(1'b0, 7'h00, q);  check("R1 ctl0", q, 0);
      rd(1'b0, 7'h18, q);  check("R1 local enable", q, 0);

      // R2 direction words
      wr(1'b0, 7'h00, 32'hFFFF_FFFF);
      rd(1'b0, 7'h00, q);  check("R2 local write ignored", q, 0);
      wr(1'b1, 7'h01, 32'hFFFF_FFFF);
      rd(1'b0, 7'h01, q);  check("R2 reserved bits", q, 32'h1111_1111);
      wr(1'b1, 7'h00, ctlw(0));
      wr(1'b1, 7'h01, ctlw(1));
      rd(1'b0, 7'h00, q);  check("R2 ctl0", q, ctlw(0));
      rd(1'b1, 7'h01, q);  check("R2 ctl1", q, ctlw(1));

      // channel sweep over the six configured channels
      for (int n = 0; n < 6; n++) begin
         bit snd, rcv;
         snd = brx[n];
         rcv = !snd;
         wr(rcv, 7'h60 + 7'(n), 32'hDEAD_BEEF);
         rd(snd, 7'h50 + 7'(n), q);
         check("R5 receiver push dropped", q, 0);
         for (int i = 0; i < 5; i++) begin
            wr(snd, 7'h60 + 7'(n), val(n, i));
            rd(rcv, 7'h50 + 7'(n), q);
            check("R3 count", q, (i < 4) ? i + 1 : 4);
         end
         rd(snd, 7'h40 + 7'(n), q);  check("R4 full bit", q, 1);
         rd(snd, 7'h60 + 7'(n), q);  check("R5 sender read", q, 0);
         rd(rcv, 7'h50 + 7'(n), q);  check("R5 sender read no pop", q, 4);
         rd(rcv, st_addr(rcv), q);   check("R6 rx bit", 32'(q[2*n]), 1);
         rd(snd, st_addr(rcv), q);   check("R9 sender sees rx bit", 32'(q[2*n]), 1);
         wr(rcv, st_addr(rcv), 32'(1) << (2*n));
         rd(rcv, st_addr(rcv), q);   check("R7 clear held while data", 32'(q[2*n]), 1);
         wr(snd, st_addr(snd), 32'(1) << (2*n+1));
         rd(snd, st_addr(snd), q);   check("R7 tx clear when full", 32'(q[2*n+1]), 0);
         for (int i = 0; i < 4; i++) begin
            rd(rcv, 7'h60 + 7'(n), q);
            check("R4 order, fifth dropped", q, val(n, i));
         end
         rd(snd, st_addr(snd), q);   check("R6 tx bit with room", 32'(q[2*n+1]), 1);
         rd(rcv, 7'h60 + 7'(n), q);  check("R5 empty read", q, 0);
         rd(rcv, 7'h40 + 7'(n), q);  check("R4 not full", q, 0);
         rd(rcv, st_addr(rcv), q);   check("R7 rx sticky", 32'(q[2*n]), 1);
         wr(rcv, st_addr(rcv), 32'(1) << (2*n));
         rd(rcv, st_addr(rcv), q);   check("R7 rx cleared", 32'(q[2*n]), 0);
         rd(snd, st_addr(rcv), q);   check("R9 consumed", 32'(q[2*n]), 0);
      end

      // channels with both or neither bit set
      for (int n = 6; n < 8; n++) begin
         wr(1'b0, 7'h60 + 7'(n), 32'h1234);
         wr(1'b1, 7'h60 + 7'(n), 32'h5678);
         rd(1'b0, 7'h50 + 7'(n), q);
         check("R5 unusable channel", q, 0);
      end

      // R8 interrupts and ownership
      wr(1'b0, 7'h18, 32'h4);
      wr(1'b1, 7'h18, 32'hFFFF);
      rd(1'b0, 7'h18, q);  check("R8 foreign enable write ignored", q, 32'h4);
      rd(1'b1, 7'h18, q);  check("R9 remote reads local enable", q, 32'h4);
      check("R8 loc_irq idle", 32'(loc_irq), 0);
      wr(1'b1, 7'h61, 32'h0BAD_F00D);
      @(negedge clk);
      check("R8 loc_irq raised", 32'(loc_irq), 1);
      check("R8 rem_irq quiet", 32'(rem_irq), 0);
      rd(1'b0, 7'h61, q);  check("R3 ch1 word", q, 32'h0BAD_F00D);
      wr(1'b0, 7'h1C, 32'h4);
      check("R8 loc_irq dropped", 32'(loc_irq), 0);
      wr(1'b1, 7'h10, 32'h8);
      check("R8 rem_irq tx bit", 32'(rem_irq), 1);
      wr(1'b1, 7'h10, 32'h0);
      check("R8 rem_irq disabled", 32'(rem_irq), 0);

      // R10 same-cycle push and pop on channel 0
      duo(1'b1, 1'b0, 7'h60, 32'hAAAA_0001, 1'b0, 1'b1, 7'h60, 32'h0, lq, rq);
      check("R10 empty pop returns 0", rq, 0);
      rd(1'b1, 7'h50, q);  check("R10 empty push kept", q, 1);
      rd(1'b1, 7'h60, q);  check("R10 empty word", q, 32'hAAAA_0001);
      for (int i = 0; i < 4; i++) wr(1'b0, 7'h60, 32'hBBBB_0000 + 32'(i));
      duo(1'b1, 1'b0, 7'h60, 32'hBBBB_0004, 1'b0, 1'b1, 7'h60, 32'h0, lq, rq);
      check("R10 full pop word", rq, 32'hBBBB_0000);
      rd(1'b1, 7'h50, q);  check("R10 full count", q, 4);
      for (int i = 1; i < 5; i++) begin
         rd(1'b1, 7'h60, q);
         check("R10 order", q, 32'hBBBB_0000 + 32'(i));
      end

      // R11 read data holds
      rd(1'b0, 7'h00, q);
      repeat (3) @(negedge clk);
      check("R11 rdata hold", loc_rdata, ctlw(0));
      check("R11 rdata value", q, ctlw(0));

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL R1 watchdog actual=running expected=done");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
         $finish;
      end
   end

endmodule